// File: doc/BRIEF.md
# Banked Abort Fault Recorder

This block captures why and where a memory access aborted and keeps that record separately for the Secure and the Non-secure world. Data-side abort events come from three places: the translation and permission check, a breakpoint or watchpoint hit, and an error response from the external memory system. From these the block picks one winner per cycle, works out its fault code, its fault address and the world to charge it to, writes the data fault status and data fault address registers of that world, and raises a one-cycle data abort request toward the core.

Instruction fetches are handled differently. A fetch that aborted leaves a tag in a small slot store, keyed by the fetch buffer slot. Nothing is recorded until the core executes that slot. Execution of a tagged slot writes the instruction fault address register and, unless a data abort wins the same cycle, the instruction fault status register, and raises a prefetch abort request. A flush drops all tags without any update. A configuration bit sends every external abort to secure monitor handling and into the Secure copies. All eight registers can be read through a combinational address/data port.

Top module: `abort_fsr_unit`

## Requirements
- R1: After reset all eight fault registers read zero and dabt_req_o, pabt_req_o and route_mon_o are low.
- R2: An MMU fault (mmu_fault_i) sets dabt_req_o in the next cycle and writes status {imprecise=0, code=mmu_code_i} and address mmu_addr_i; a status register reads with bit 5 as the imprecise flag and bits 4:0 as the code.
- R3: A debug hit writes code 0x02 with dbg_addr_i only while dbg_en_i is high; with dbg_en_i low a lone debug hit raises no request and leaves every register unchanged.
- R4: Among data-side events in one cycle the MMU fault wins over debug, and debug wins over external; only the winner is recorded.
- R5: An imprecise external abort (ext_precise_i low, kind single or burst) writes status {1, 0x16} and address zero.
- R6: A precise external abort writes code 0x08; for kind 0 (single) the address is ext_addr_i, for kind 1 (burst) it is the burst base ext_base_i.
- R7: An external abort of kind 2 (table walk) is precise regardless of ext_precise_i and writes code 0x0C with ext_addr_i.
- R8: An external abort of kind 3 (translation operation) is precise, writes code 0x08 with ext_addr_i, and is recorded in the world given by xlat_secure_i.
- R9: With cfg_ext_route_i low an abort is recorded in the world of core_secure_i (1 = Secure); with it high every external abort goes to the Secure copies and route_mon_o is high in the next cycle, while non-external aborts keep the core's world.
- R10: A fetch tag with the abort flag produces nothing until its slot is executed; execution raises pabt_req_o in the next cycle and writes the instruction fault address and status {0, fetch code} of the core's world (Secure if the tag is external and routing is on).
- R11: flush_i discards all tags, including one executed in the same cycle: no prefetch request and no instruction register update follow.
- R12: When a data abort and a prefetch abort occur in the same cycle, only dabt_req_o is raised; the instruction fault address is still written, the instruction fault status is not.
- R13: rd_addr_i bit 2 selects Non-secure (1) or Secure (0); bits 1:0 select data status (0), instruction status (1), data address (2), instruction address (3); status values are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_ext_route_i | input | 1 | Route all external aborts to Secure monitor |
| core_secure_i | input | 1 | Core security state, 1 = Secure |
| mmu_fault_i | input | 1 | Data-side MMU fault this cycle |
| mmu_code_i | input | 5 | Fault code of the MMU fault |
| mmu_addr_i | input | AW | Faulting address of the MMU fault |
| dbg_en_i | input | 1 | Monitor debug enabled |
| dbg_hit_i | input | 1 | Breakpoint or watchpoint hit |
| dbg_addr_i | input | AW | Address of the debug hit |
| ext_err_i | input | 1 | External memory error on a data-side access |
| ext_kind_i | input | 2 | 0 single, 1 burst, 2 table walk, 3 translation operation |
| ext_precise_i | input | 1 | External error is precise (kinds 0 and 1) |
| ext_addr_i | input | AW | Address of the failing access |
| ext_base_i | input | AW | Base address of the failing burst |
| xlat_secure_i | input | 1 | World that issued the translation operation |
| fetch_wr_i | input | 1 | Write a fetch tag |
| fetch_slot_i | input | SW | Slot of the fetch tag |
| fetch_abort_i | input | 1 | Fetch aborted |
| fetch_ext_i | input | 1 | Fetch abort was external |
| fetch_code_i | input | 5 | Fault code of the fetch abort |
| fetch_addr_i | input | AW | Instruction address |
| exec_en_i | input | 1 | Core executes a slot |
| exec_slot_i | input | SW | Executed slot |
| flush_i | input | 1 | Discard all fetch tags |
| rd_addr_i | input | 3 | Register select |
| rd_data_o | output | AW | Register read data |
| dabt_req_o | output | 1 | Data abort request |
| pabt_req_o | output | 1 | Prefetch abort request |
| route_mon_o | output | 1 | Abort taken to secure monitor |

## Verification
The assertions assume that a fetch tag is never written into the slot being executed in the same cycle and that the inputs are held low during reset; the bench writes tags and executes slots in separate cycles and idles all inputs through reset. They also take ext_kind_i as meaningful only while ext_err_i is high, and the bench only varies it then. Data-side events are driven for exactly one cycle and then cleared, so each request pulse and register change can be traced to one stimulus cycle.

// File: rtl/abort_pkg.sv
package abort_pkg;
  localparam int unsigned FC_W = 5;
  localparam int unsigned FSR_W = FC_W + 1;

  localparam logic [FC_W-1:0] FC_DEBUG      = 5'h02;
  localparam logic [FC_W-1:0] FC_EXT_PREC   = 5'h08;
  localparam logic [FC_W-1:0] FC_EXT_WALK   = 5'h0C;
  localparam logic [FC_W-1:0] FC_EXT_IMPREC = 5'h16;

  typedef enum logic [1:0] {
    EXT_SINGLE = 2'd0,
    EXT_BURST  = 2'd1,
    EXT_WALK   = 2'd2,
    EXT_XLAT   = 2'd3
  } ext_kind_e;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_MMU,
    SRC_DBG,
    SRC_EXT
  } dsrc_e;

  typedef struct packed {
    logic            imprecise;
    logic [FC_W-1:0] code;
  } fsr_t;

  // register select, bits 1:0
  localparam logic [1:0] RSEL_DFSR = 2'd0;
  localparam logic [1:0] RSEL_IFSR = 2'd1;
  localparam logic [1:0] RSEL_DFAR = 2'd2;
  localparam logic [1:0] RSEL_IFAR = 2'd3;
endpackage

// File: rtl/abort_data_arb.sv
module abort_data_arb
  import abort_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                 route_i,
  input  logic                 core_secure_i,
  input  logic                 mmu_fault_i,
  input  logic [FC_W-1:0]      mmu_code_i,
  input  logic [AW-1:0]        mmu_addr_i,
  input  logic                 dbg_en_i,
  input  logic                 dbg_hit_i,
  input  logic [AW-1:0]        dbg_addr_i,
  input  logic                 ext_err_i,
  input  logic [1:0]           ext_kind_i,
  input  logic                 ext_precise_i,
  input  logic [AW-1:0]        ext_addr_i,
  input  logic [AW-1:0]        ext_base_i,
  input  logic                 xlat_secure_i,
  output logic                 hit_o,
  output fsr_t                 fsr_o,
  output logic [AW-1:0]        far_o,
  output logic                 secure_o,
  output logic                 to_mon_o
);
  dsrc_e     src;
  ext_kind_e kind;
  logic      ext_prec;

  assign kind     = ext_kind_e'(ext_kind_i);
  assign ext_prec = ext_precise_i || (kind == EXT_WALK) || (kind == EXT_XLAT);

  always_comb begin
    if (mmu_fault_i)                src = SRC_MMU;
    else if (dbg_en_i && dbg_hit_i) src = SRC_DBG;
    else if (ext_err_i)             src = SRC_EXT;
    else                            src = SRC_NONE;
  end

  always_comb begin
    hit_o    = 1'b0;
    fsr_o    = '0;
    far_o    = '0;
    secure_o = core_secure_i;
    to_mon_o = 1'b0;
    unique case (src)
      SRC_MMU: begin
        hit_o = 1'b1;
        fsr_o = '{imprecise: 1'b0, code: mmu_code_i};
        far_o = mmu_addr_i;
      end
      SRC_DBG: begin
        hit_o = 1'b1;
        fsr_o = '{imprecise: 1'b0, code: FC_DEBUG};
        far_o = dbg_addr_i;
      end
      SRC_EXT: begin
        hit_o    = 1'b1;
        to_mon_o = route_i;
        if (route_i)                secure_o = 1'b1;
        else if (kind == EXT_XLAT)  secure_o = xlat_secure_i;
        if (!ext_prec) begin
          fsr_o = '{imprecise: 1'b1, code: FC_EXT_IMPREC};
          far_o = '0;
        end else begin
          unique case (kind)
            EXT_BURST: begin
              fsr_o = '{imprecise: 1'b0, code: FC_EXT_PREC};
              far_o = ext_base_i;
            end
            EXT_WALK: begin
              fsr_o = '{imprecise: 1'b0, code: FC_EXT_WALK};
              far_o = ext_addr_i;
            end
            default: begin
              fsr_o = '{imprecise: 1'b0, code: FC_EXT_PREC};
              far_o = ext_addr_i;
            end
          endcase
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/abort_fetch_tags.sv
module abort_fetch_tags
  import abort_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned NSLOT = 4,
  localparam int unsigned SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [SW-1:0]   wr_slot_i,
  input  logic            wr_abort_i,
  input  logic            wr_ext_i,
  input  logic [FC_W-1:0] wr_code_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic            exec_en_i,
  input  logic [SW-1:0]   exec_slot_i,
  input  logic            flush_i,
  output logic            pabt_hit_o,
  output logic            pabt_ext_o,
  output logic [FC_W-1:0] pabt_code_o,
  output logic [AW-1:0]   pabt_addr_o
);
  logic            vld_q  [NSLOT];
  logic            abt_q  [NSLOT];
  logic            ext_q  [NSLOT];
  logic [FC_W-1:0] code_q [NSLOT];
  logic [AW-1:0]   addr_q [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic wr_sel, ex_sel;
    assign wr_sel = wr_en_i && (wr_slot_i == SW'(g));
    assign ex_sel = exec_en_i && (exec_slot_i == SW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        abt_q[g]  <= 1'b0;
        ext_q[g]  <= 1'b0;
        code_q[g] <= '0;
        addr_q[g] <= '0;
      end else if (wr_sel) begin
        vld_q[g]  <= 1'b1;
        abt_q[g]  <= wr_abort_i;
        ext_q[g]  <= wr_ext_i;
        code_q[g] <= wr_code_i;
        addr_q[g] <= wr_addr_i;
      end else if (flush_i || ex_sel) begin
        vld_q[g] <= 1'b0;
      end
    end
  end

  // flush in the same cycle kills the execution
  assign pabt_hit_o  = exec_en_i && !flush_i && vld_q[exec_slot_i] && abt_q[exec_slot_i];
  assign pabt_ext_o  = ext_q[exec_slot_i];
  assign pabt_code_o = code_q[exec_slot_i];
  assign pabt_addr_o = addr_q[exec_slot_i];
endmodule

// File: rtl/abort_bank_regs.sv
module abort_bank_regs
  import abort_pkg::*;
#(
  parameter int unsigned AW = 32,
  localparam int unsigned PAD = AW - FSR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          d_we_i,
  input  logic          d_sec_i,
  input  fsr_t          d_fsr_i,
  input  logic [AW-1:0] d_far_i,
  input  logic          i_far_we_i,
  input  logic          i_fsr_we_i,
  input  logic          i_sec_i,
  input  fsr_t          i_fsr_i,
  input  logic [AW-1:0] i_far_i,
  input  logic [2:0]    rd_addr_i,
  output logic [AW-1:0] rd_data_o
);
  // bank index: 0 Secure, 1 Non-secure
  fsr_t          dfsr_q [2];
  fsr_t          ifsr_q [2];
  logic [AW-1:0] dfar_q [2];
  logic [AW-1:0] ifar_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic sel_d, sel_i;
    assign sel_d = (d_sec_i == (b == 0));
    assign sel_i = (i_sec_i == (b == 0));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dfsr_q[b] <= '0;
        dfar_q[b] <= '0;
      end else if (d_we_i && sel_d) begin
        dfsr_q[b] <= d_fsr_i;
        dfar_q[b] <= d_far_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ifsr_q[b] <= '0;
        ifar_q[b] <= '0;
      end else begin
        if (i_fsr_we_i && sel_i) ifsr_q[b] <= i_fsr_i;
        if (i_far_we_i && sel_i) ifar_q[b] <= i_far_i;
      end
    end
  end

  always_comb begin
    unique case (rd_addr_i[1:0])
      RSEL_DFSR: rd_data_o = {{PAD{1'b0}}, dfsr_q[rd_addr_i[2]]};
      RSEL_IFSR: rd_data_o = {{PAD{1'b0}}, ifsr_q[rd_addr_i[2]]};
      RSEL_DFAR: rd_data_o = dfar_q[rd_addr_i[2]];
      default:   rd_data_o = ifar_q[rd_addr_i[2]];
    endcase
  end
endmodule

// File: rtl/abort_fsr_unit.sv
module abort_fsr_unit
  import abort_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned NSLOT = 4,
  localparam int unsigned SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_ext_route_i,
  input  logic            core_secure_i,
  input  logic            mmu_fault_i,
  input  logic [4:0]      mmu_code_i,
  input  logic [AW-1:0]   mmu_addr_i,
  input  logic            dbg_en_i,
  input  logic            dbg_hit_i,
  input  logic [AW-1:0]   dbg_addr_i,
  input  logic            ext_err_i,
  input  logic [1:0]      ext_kind_i,
  input  logic            ext_precise_i,
  input  logic [AW-1:0]   ext_addr_i,
  input  logic [AW-1:0]   ext_base_i,
  input  logic            xlat_secure_i,
  input  logic            fetch_wr_i,
  input  logic [SW-1:0]   fetch_slot_i,
  input  logic            fetch_abort_i,
  input  logic            fetch_ext_i,
  input  logic [4:0]      fetch_code_i,
  input  logic [AW-1:0]   fetch_addr_i,
  input  logic            exec_en_i,
  input  logic [SW-1:0]   exec_slot_i,
  input  logic            flush_i,
  input  logic [2:0]      rd_addr_i,
  output logic [AW-1:0]   rd_data_o,
  output logic            dabt_req_o,
  output logic            pabt_req_o,
  output logic            route_mon_o
);
  logic            d_hit, d_sec, d_mon;
  fsr_t            d_fsr;
  logic [AW-1:0]   d_far;
  logic            p_hit, p_ext, p_sec, p_mon;
  logic [FC_W-1:0] p_code;
  logic [AW-1:0]   p_addr;
  logic            dabt_q, pabt_q, mon_q;

  abort_data_arb #(.AW(AW)) u_arb (
    .route_i       (cfg_ext_route_i),
    .core_secure_i (core_secure_i),
    .mmu_fault_i   (mmu_fault_i),
    .mmu_code_i    (mmu_code_i),
    .mmu_addr_i    (mmu_addr_i),
    .dbg_en_i      (dbg_en_i),
    .dbg_hit_i     (dbg_hit_i),
    .dbg_addr_i    (dbg_addr_i),
    .ext_err_i     (ext_err_i),
    .ext_kind_i    (ext_kind_i),
    .ext_precise_i (ext_precise_i),
    .ext_addr_i    (ext_addr_i),
    .ext_base_i    (ext_base_i),
    .xlat_secure_i (xlat_secure_i),
    .hit_o         (d_hit),
    .fsr_o         (d_fsr),
    .far_o         (d_far),
    .secure_o      (d_sec),
    .to_mon_o      (d_mon)
  );

  abort_fetch_tags #(.AW(AW), .NSLOT(NSLOT)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (fetch_wr_i),
    .wr_slot_i   (fetch_slot_i),
    .wr_abort_i  (fetch_abort_i),
    .wr_ext_i    (fetch_ext_i),
    .wr_code_i   (fetch_code_i),
    .wr_addr_i   (fetch_addr_i),
    .exec_en_i   (exec_en_i),
    .exec_slot_i (exec_slot_i),
    .flush_i     (flush_i),
    .pabt_hit_o  (p_hit),
    .pabt_ext_o  (p_ext),
    .pabt_code_o (p_code),
    .pabt_addr_o (p_addr)
  );

  assign p_mon = p_ext && cfg_ext_route_i;
  assign p_sec = p_mon || core_secure_i;

  abort_bank_regs #(.AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .d_we_i     (d_hit),
    .d_sec_i    (d_sec),
    .d_fsr_i    (d_fsr),
    .d_far_i    (d_far),
    .i_far_we_i (p_hit),
    .i_fsr_we_i (p_hit && !d_hit),
    .i_sec_i    (p_sec),
    .i_fsr_i    ('{imprecise: 1'b0, code: p_code}),
    .i_far_i    (p_addr),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dabt_q <= 1'b0;
      pabt_q <= 1'b0;
      mon_q  <= 1'b0;
    end else begin
      dabt_q <= d_hit;
      pabt_q <= p_hit && !d_hit;
      mon_q  <= d_hit ? d_mon : (p_hit && p_mon);
    end
  end

  assign dabt_req_o  = dabt_q;
  assign pabt_req_o  = pabt_q;
  assign route_mon_o = mon_q;
endmodule

// File: rtl/abort_fsr_chk.sv
module abort_fsr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_ext_route_i,
  input logic mmu_fault_i,
  input logic dbg_en_i,
  input logic dbg_hit_i,
  input logic ext_err_i,
  input logic exec_en_i,
  input logic flush_i,
  input logic dabt_req_o,
  input logic pabt_req_o,
  input logic route_mon_o
);
  assert_mmu_dabt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmu_fault_i |=> dabt_req_o);

  assert_dbg_off_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mmu_fault_i && !ext_err_i && !dbg_en_i && dbg_hit_i) |=> !dabt_req_o);

  assert_ext_route_mon_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_err_i && cfg_ext_route_i && !mmu_fault_i && !(dbg_en_i && dbg_hit_i)) |=> route_mon_o);

  assert_pabt_needs_exec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_en_i |=> !pabt_req_o);

  assert_flush_no_pabt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !pabt_req_o);

  assert_dabt_over_pabt_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dabt_req_o && pabt_req_o));
endmodule

bind abort_fsr_unit abort_fsr_chk u_chk (.*);

// File: tb/sim_abort_fsr_unit.sv
module sim_abort_fsr_unit;
  localparam int CLK_P = 20;
  localparam int AW = 32;
  localparam logic [31:0] MA = 32'h1000_0010, DA = 32'h2000_0024;
  localparam logic [31:0] EA = 32'h3000_0038, EB = 32'h3000_0030;

  typedef struct packed {
    logic [3:0]  req;
    logic        mmu, den, dbg, ext;
    logic [1:0]  kind;
    logic        prec, csec, route, xsec;
    logic        e_dabt, e_sec;
    logic [5:0]  e_fsr;
    logic [31:0] e_far;
    logic        e_mon;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 1,0,0,0, 2'd0, 0, 1,0,0, 1,1, 6'h05, MA, 0},   // R2
    '{4'd9, 1,0,0,0, 2'd0, 0, 0,0,0, 1,0, 6'h05, MA, 0},   // R9
    '{4'd3, 0,1,1,0, 2'd0, 0, 1,0,0, 1,1, 6'h02, DA, 0},   // R3
    '{4'd3, 0,0,1,0, 2'd0, 0, 0,0,0, 0,0, 6'h00, 0,  0},   // R3 ignored
    '{4'd4, 1,1,1,1, 2'd0, 1, 0,0,0, 1,0, 6'h05, MA, 0},   // R4
    '{4'd4, 0,1,1,1, 2'd0, 1, 1,0,0, 1,1, 6'h02, DA, 0},   // R4
    '{4'd5, 0,0,0,1, 2'd0, 0, 0,0,0, 1,0, 6'h36, 0,  0},   // R5
    '{4'd6, 0,0,0,1, 2'd0, 1, 1,0,0, 1,1, 6'h08, EA, 0},   // R6
    '{4'd6, 0,0,0,1, 2'd1, 1, 0,0,0, 1,0, 6'h08, EB, 0},   // R6
    '{4'd7, 0,0,0,1, 2'd2, 0, 1,0,0, 1,1, 6'h0C, EA, 0},   // R7
    '{4'd8, 0,0,0,1, 2'd3, 0, 1,0,0, 1,0, 6'h08, EA, 0},   // R8
    '{4'd9, 0,0,0,1, 2'd1, 1, 0,1,0, 1,1, 6'h08, EB, 1},   // R9
    '{4'd9, 1,0,0,0, 2'd0, 0, 0,1,0, 1,0, 6'h05, MA, 0},   // R9
    '{4'd9, 0,0,0,1, 2'd0, 0, 0,1,0, 1,1, 6'h36, 0,  1}    // R9
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic route, csec, mmu, den, dbg, ext, prec, xsec;
  logic [4:0] mcode, fcode;
  logic [1:0] kind, fslot, xslot;
  logic fwr, fabt, fext, xen, flush;
  logic [31:0] faddr;
  logic [2:0] ra;
  logic [31:0] rd;
  logic dabt, pabt, mon;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  abort_fsr_unit #(.AW(AW), .NSLOT(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_ext_route_i(route), .core_secure_i(csec),
    .mmu_fault_i(mmu), .mmu_code_i(mcode), .mmu_addr_i(MA),
    .dbg_en_i(den), .dbg_hit_i(dbg), .dbg_addr_i(DA),
    .ext_err_i(ext), .ext_kind_i(kind), .ext_precise_i(prec),
    .ext_addr_i(EA), .ext_base_i(EB), .xlat_secure_i(xsec),
    .fetch_wr_i(fwr), .fetch_slot_i(fslot), .fetch_abort_i(fabt), .fetch_ext_i(fext),
    .fetch_code_i(fcode), .fetch_addr_i(faddr),
    .exec_en_i(xen), .exec_slot_i(xslot), .flush_i(flush),
    .rd_addr_i(ra), .rd_data_o(rd),
    .dabt_req_o(dabt), .pabt_req_o(pabt), .route_mon_o(mon)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    route = 0; csec = 0; mmu = 0; den = 0; dbg = 0; ext = 0; prec = 0; xsec = 0;
    mcode = 5'h05; kind = 0; fwr = 0; fslot = 0; fabt = 0; fext = 0; fcode = 0;
    faddr = 0; xen = 0; xslot = 0; flush = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [31:0] d);
    ra = a; #1; d = rd;
  endtask

  task automatic snap(output logic [31:0] s [8]);
    for (int k = 0; k < 8; k++) rdreg(3'(k), s[k]);
  endtask

  task automatic cmp_all(input string req, input logic [31:0] e [8]);
    logic [31:0] v;
    for (int k = 0; k < 8; k++) begin
      rdreg(3'(k), v);
      chk($sformatf("%s reg%0d", req, k), v, e[k]);
    end
  endtask

  task automatic put_tag(input logic [1:0] s, input logic a, input logic x,
                         input logic [4:0] c, input logic [31:0] ad);
    fwr = 1; fslot = s; fabt = a; fext = x; fcode = c; faddr = ad;
    tick(); fwr = 0;
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s [8];
    logic [31:0] e [8];
    string tg;
    idle(); ra = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 dabt", 32'(dabt), 0);
    chk("R1 pabt", 32'(pabt), 0);
    chk("R1 mon", 32'(mon), 0);
    for (int k = 0; k < 8; k++) e[k] = '0;
    cmp_all("R1", e);

    // data-side table, R13 map used for expected placement
    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      tg = $sformatf("R%0d vec%0d", v.req, i);
      snap(s);
      e = s;
      route = v.route; csec = v.csec; mmu = v.mmu; den = v.den; dbg = v.dbg;
      ext = v.ext; kind = v.kind; prec = v.prec; xsec = v.xsec;
      tick();
      idle();
      chk({tg, " dabt"}, 32'(dabt), 32'(v.e_dabt));
      chk({tg, " mon"}, 32'(mon), 32'(v.e_mon));
      if (v.e_dabt) begin
        e[{!v.e_sec, 2'd0}] = {26'd0, v.e_fsr};
        e[{!v.e_sec, 2'd2}] = v.e_far;
      end
      cmp_all(tg, e);
    end

    // R10 deferred prefetch abort, core Non-secure
    put_tag(2'd1, 1, 0, 5'h05, 32'h4000_0100);
    tick();
    chk("R10 no pabt before exec", 32'(pabt), 0);
    snap(s);
    chk("R10 IFAR NS untouched", s[7], 0);
    xen = 1; xslot = 2'd1; csec = 0;
    tick(); idle();
    chk("R10 pabt", 32'(pabt), 1);
    rdreg(3'd7, s[7]); chk("R10 IFAR NS R13", s[7], 32'h4000_0100);
    rdreg(3'd5, s[5]); chk("R10 IFSR NS R13", s[5], 32'h05);
    rdreg(3'd3, s[3]); chk("R10 IFAR S untouched", s[3], 0);
    tick();
    chk("R10 pabt one cycle", 32'(pabt), 0);

    // R10 executed tag without abort
    put_tag(2'd2, 0, 0, 5'h05, 32'h4000_0200);
    xen = 1; xslot = 2'd2;
    tick(); idle();
    chk("R10 clean fetch", 32'(pabt), 0);
    rdreg(3'd7, s[7]); chk("R10 clean IFAR", s[7], 32'h4000_0100);

    // R11 flush then execute
    put_tag(2'd3, 1, 0, 5'h07, 32'h4000_0300);
    flush = 1; tick(); idle();
    xen = 1; xslot = 2'd3; tick(); idle();
    chk("R11 flushed exec", 32'(pabt), 0);
    rdreg(3'd7, s[7]); chk("R11 IFAR", s[7], 32'h4000_0100);
    // R11 flush with exec in the same cycle
    put_tag(2'd0, 1, 0, 5'h07, 32'h4000_0400);
    flush = 1; xen = 1; xslot = 2'd0; tick(); idle();
    chk("R11 same-cycle flush", 32'(pabt), 0);
    rdreg(3'd5, s[5]); chk("R11 IFSR", s[5], 32'h05);

    // R12 data and prefetch together, core Secure
    put_tag(2'd0, 1, 1, 5'h0C, 32'h4000_0500);
    rdreg(3'd1, s[1]);
    xen = 1; xslot = 2'd0; mmu = 1; mcode = 5'h05; csec = 1;
    tick(); idle();
    chk("R12 dabt", 32'(dabt), 1);
    chk("R12 pabt", 32'(pabt), 0);
    rdreg(3'd3, s[3]); chk("R12 IFAR S", s[3], 32'h4000_0500);
    rdreg(3'd1, s[0]); chk("R12 IFSR S kept", s[0], s[1]);
    rdreg(3'd2, s[2]); chk("R12 DFAR S", s[2], MA);

    // R9 routed external fetch abort, core Non-secure
    put_tag(2'd1, 1, 1, 5'h08, 32'h4000_0600);
    route = 1; csec = 0; xen = 1; xslot = 2'd1;
    tick(); idle();
    chk("R9 fetch pabt", 32'(pabt), 1);
    chk("R9 fetch mon", 32'(mon), 1);
    rdreg(3'd3, s[3]); chk("R9 IFAR S", s[3], 32'h4000_0600);
    rdreg(3'd1, s[1]); chk("R9 IFSR S", s[1], 32'h08);
    rdreg(3'd7, s[7]); chk("R9 IFAR NS kept", s[7], 32'h4000_0100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule